// File: doc/BRIEF.md
# SPI NOR Flash Command Responder

This block models the target side of a serial NOR flash at byte granularity. Each cycle in which the chip-select is low and the transfer strobe is high carries one received byte into the block. The block returns one response byte for that same transfer on a combinational output. The first byte of a selected frame is an opcode. The block collects address bytes where the opcode needs them and then serves data from, or writes data into, a small internal byte array. Raising the chip-select ends any command in progress and returns the decoder to opcode collection.

The supported operations are:
- identification read, padded with zeros to a fixed length;
- read;
- page program, which can only clear bits;
- setting and clearing of the write-enable latch;
- whole-array erase under write-enable protection;
- a two-step memory reset that needs an arming opcode immediately before it.

Any other opcode turns the rest of the frame into a stream of zero bytes. Two one-cycle indications report a refused erase and an attempt to program a 0 bit back to 1.

Top module: `spi_nor_responder`

## Requirements
- R1: After reset every storage byte reads 0xFF, the write-enable latch (`wel`) is 0, and both indications `erase_err` and `prog_warn` are 0.
- R2: Opcode 0x9F returns the ID bytes 0x20, 0xBA, 0x19 on the next three transfers and 0x00 on the three after that. The decoder then returns to opcode collection.
- R3: Opcode 0x03 is followed by three address bytes, most significant first. Each later transfer returns the byte at the current address and then advances the address. Only the low log2(DEPTH) address bits are used, so the address wraps modulo the storage size.
- R4: Opcode 0x02 is followed by three address bytes. Each later byte is stored as the old byte AND the new byte, with the same address advance and wrap as R3. `wel` clears once the address phase completes.
- R5: `prog_warn` is 1 for exactly the cycle after a program transfer whose data has a 1 where the stored byte has a 0. Otherwise it is 0.
- R6: Opcode 0x06 sets `wel` and opcode 0x04 clears it, each visible in the cycle after the opcode transfer.
- R7: Opcode 0x60 or 0xC7 with `wel` set turns every byte to 0xFF and clears `wel`. With `wel` clear, storage is left unchanged and `erase_err` is 1 for the following cycle.
- R8: An opcode not listed in R2 to R10 makes every following transfer of the frame return 0x00, whatever byte is received.
- R9: Chip-select high returns the decoder to opcode collection. The first byte of the next frame is always decoded as an opcode.
- R10: Opcode 0x99 resets the device state (clears `wel`) only when the previous decoded opcode was 0x66. Any other opcode between them disarms the reset.
- R11: Outside a read, ID or data-stream phase the response byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip-select; high ends the frame |
| xfer_en | input | 1 | One byte is transferred in this cycle |
| rx_byte | input | 8 | Byte received from the host |
| tx_byte | output | 8 | Response byte for the current transfer |
| wel | output | 1 | Write-enable latch |
| erase_err | output | 1 | One-cycle pulse: erase refused |
| prog_warn | output | 1 | One-cycle pulse: program tried to set a 0 bit to 1 |

## Verification
The assertions assume that `xfer_en` is only meaningful while `cs_n` is low. They also assume that a frame lasts at least one cycle with chip-select high between frames, so the idle state after a deselect is visible before the next opcode. The bench drives every input on the falling edge, drops the strobe right after each rising edge, and inserts a full deselect cycle between frames. It therefore never presents a byte while chip-select is high and never overlaps two transfers in one cycle.

// File: rtl/spi_nor_pkg.sv
package spi_nor_pkg;

    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_ADDR,
        PH_READ,
        PH_PROG,
        PH_STREAM
    } phase_e;

    localparam logic [7:0] OP_ID      = 8'h9F;
    localparam logic [7:0] OP_READ    = 8'h03;
    localparam logic [7:0] OP_PROG    = 8'h02;
    localparam logic [7:0] OP_WREN    = 8'h06;
    localparam logic [7:0] OP_WRDI    = 8'h04;
    localparam logic [7:0] OP_ERASE_A = 8'h60;
    localparam logic [7:0] OP_ERASE_B = 8'hC7;
    localparam logic [7:0] OP_ARM     = 8'h66;
    localparam logic [7:0] OP_RESET   = 8'h99;

    function automatic logic is_erase(input logic [7:0] op);
        return (op == OP_ERASE_A) || (op == OP_ERASE_B);
    endfunction

endpackage

// File: rtl/spi_nor_id_gen.sv
module spi_nor_id_gen #(
    parameter int ID_LEN  = 3,
    parameter int ID_MAX  = 6,
    parameter logic [8*ID_LEN-1:0] ID_WORD = 24'h20BA19,
    localparam int PW = $clog2(ID_MAX + 1)
) (
    input  logic [PW-1:0] pos,
    output logic [7:0]    id_byte
);
    logic [7:0] tbl [ID_MAX];

    for (genvar g = 0; g < ID_MAX; g++) begin : g_tbl
        if (g < ID_LEN) begin : g_real
            assign tbl[g] = ID_WORD[8*(ID_LEN-1-g) +: 8];
        end else begin : g_pad
            assign tbl[g] = 8'h00;
        end
    end

    assign id_byte = (int'(pos) < ID_MAX) ? tbl[pos] : 8'h00;
endmodule

// File: rtl/spi_nor_store.sv
module spi_nor_store #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          erase,
    input  logic          prog_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    prog_byte,
    output logic [7:0]    rd_data
);
    logic [7:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        logic [7:0] row_d;
        always_comb begin
            row_d = mem_q[g];
            if (erase) begin
                row_d = 8'hFF;
            end else if (prog_en && (addr == AW'(g))) begin
                row_d = mem_q[g] & prog_byte;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= 8'hFF;
            else        mem_q[g] <= row_d;
        end
    end

    assign rd_data = mem_q[addr];
endmodule

// File: rtl/spi_nor_responder.sv
module spi_nor_responder
    import spi_nor_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int ADDR_BYTES = 3,
    parameter int ID_LEN     = 3,
    parameter int ID_MAX     = 6,
    parameter logic [8*ID_LEN-1:0] ID_WORD = 24'h20BA19
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       xfer_en,
    input  logic [7:0] rx_byte,
    output logic [7:0] tx_byte,
    output logic       wel,
    output logic       erase_err,
    output logic       prog_warn
);
    localparam int AW    = $clog2(DEPTH);
    localparam int FULLW = 8 * ADDR_BYTES;
    localparam int CW    = $clog2(ADDR_BYTES + 1);
    localparam int PW    = $clog2(ID_MAX + 1);

    typedef struct packed {
        phase_e           ph;
        logic             id_mode;
        logic             is_prog;
        logic [CW-1:0]    cnt;
        logic [FULLW-1:0] addr;
        logic [PW-1:0]    pos;
        logic             arm;
        logic             wel;
        logic             err;
        logic             warn;
    } ctl_t;

    ctl_t       cur_q, nxt_d;
    logic       erase_d, prog_d;
    logic [7:0] rd_data, id_byte;
    logic       at_opcode;

    spi_nor_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase     (erase_d),
        .prog_en   (prog_d),
        .addr      (cur_q.addr[AW-1:0]),
        .prog_byte (rx_byte),
        .rd_data   (rd_data)
    );

    spi_nor_id_gen #(.ID_LEN(ID_LEN), .ID_MAX(ID_MAX), .ID_WORD(ID_WORD)) u_id (
        .pos     (cur_q.pos),
        .id_byte (id_byte)
    );

    always_comb begin
        nxt_d   = cur_q;
        nxt_d.err  = 1'b0;
        nxt_d.warn = 1'b0;
        erase_d = 1'b0;
        prog_d  = 1'b0;

        unique case (cur_q.ph)
            PH_READ:   tx_byte = rd_data;
            PH_STREAM: tx_byte = cur_q.id_mode ? id_byte : 8'h00;
            default:   tx_byte = 8'h00;
        endcase

        if (cs_n) begin
            nxt_d.ph  = PH_OPCODE;
            nxt_d.cnt = '0;
            nxt_d.pos = '0;
        end else if (xfer_en) begin
            unique case (cur_q.ph)
                PH_OPCODE: begin
                    if (rx_byte != OP_RESET) nxt_d.arm = 1'b0;
                    if (rx_byte == OP_ID) begin
                        nxt_d.ph = PH_STREAM;
                        nxt_d.id_mode = 1'b1;
                        nxt_d.pos = '0;
                    end else if (rx_byte == OP_READ || rx_byte == OP_PROG) begin
                        nxt_d.ph = PH_ADDR;
                        nxt_d.is_prog = (rx_byte == OP_PROG);
                        nxt_d.cnt = '0;
                        nxt_d.addr = '0;
                    end else if (rx_byte == OP_WREN) begin
                        nxt_d.wel = 1'b1;
                    end else if (rx_byte == OP_WRDI) begin
                        nxt_d.wel = 1'b0;
                    end else if (is_erase(rx_byte)) begin
                        if (cur_q.wel) begin
                            erase_d = 1'b1;
                            nxt_d.wel = 1'b0;
                        end else begin
                            nxt_d.err = 1'b1;
                        end
                    end else if (rx_byte == OP_ARM) begin
                        nxt_d.arm = 1'b1;
                    end else if (rx_byte == OP_RESET) begin
                        if (cur_q.arm) begin
                            nxt_d.wel = 1'b0;
                            nxt_d.arm = 1'b0;
                            nxt_d.id_mode = 1'b0;
                            nxt_d.is_prog = 1'b0;
                        end
                    end else begin
                        nxt_d.ph = PH_STREAM;
                        nxt_d.id_mode = 1'b0;
                    end
                end
                PH_ADDR: begin
                    nxt_d.addr = {cur_q.addr[FULLW-9:0], rx_byte};
                    if (cur_q.cnt == CW'(ADDR_BYTES - 1)) begin
                        nxt_d.cnt = '0;
                        if (cur_q.is_prog) begin
                            nxt_d.ph  = PH_PROG;
                            nxt_d.wel = 1'b0;
                        end else begin
                            nxt_d.ph = PH_READ;
                        end
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
                PH_READ: begin
                    nxt_d.addr = cur_q.addr + 1'b1;
                end
                PH_PROG: begin
                    prog_d = 1'b1;
                    nxt_d.warn = |(~rd_data & rx_byte);
                    nxt_d.addr = cur_q.addr + 1'b1;
                end
                PH_STREAM: begin
                    if (cur_q.id_mode) begin
                        if (cur_q.pos == PW'(ID_MAX - 1)) begin
                            nxt_d.ph  = PH_OPCODE;
                            nxt_d.pos = '0;
                        end else begin
                            nxt_d.pos = cur_q.pos + 1'b1;
                        end
                    end
                end
                default: nxt_d.ph = PH_OPCODE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{ph: PH_OPCODE, id_mode: 1'b0, is_prog: 1'b0, cnt: '0,
                       addr: '0, pos: '0, arm: 1'b0, wel: 1'b0, err: 1'b0,
                       warn: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign at_opcode = (cur_q.ph == PH_OPCODE);
    assign wel       = cur_q.wel;
    assign erase_err = cur_q.err;
    assign prog_warn = cur_q.warn;
endmodule

// File: rtl/spi_nor_responder_chk.sv
module spi_nor_responder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       xfer_en,
    input logic [7:0] rx_byte,
    input logic [7:0] tx_byte,
    input logic       wel,
    input logic       erase_err,
    input logic       prog_warn,
    input logic       at_opcode
);
    logic op_xfer;
    assign op_xfer = xfer_en && !cs_n && at_opcode;

    p_wren_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_xfer && rx_byte == 8'h06) |=> wel);

    p_wrdi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_xfer && rx_byte == 8'h04) |=> !wel);

    p_erase_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_xfer && (rx_byte == 8'h60 || rx_byte == 8'hC7) && wel) |=> (!wel && !erase_err));

    p_erase_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_xfer && (rx_byte == 8'h60 || rx_byte == 8'hC7) && !wel) |=> erase_err);

    p_err_needs_nowel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_err |-> $past(!wel));

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erase_err, prog_warn}));

    p_deselect_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> at_opcode);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        at_opcode |-> (tx_byte == 8'h00));
endmodule

bind spi_nor_responder spi_nor_responder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .xfer_en   (xfer_en),
    .rx_byte   (rx_byte),
    .tx_byte   (tx_byte),
    .wel       (wel),
    .erase_err (erase_err),
    .prog_warn (prog_warn),
    .at_opcode (at_opcode)
);

// File: tb/spi_nor_responder_bench.sv
module spi_nor_responder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       xfer_en = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [7:0] tx_byte;
    logic       wel, erase_err, prog_warn;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    spi_nor_responder u_spi_nor_responder (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .xfer_en   (xfer_en),
        .rx_byte   (rx_byte),
        .tx_byte   (tx_byte),
        .wel       (wel),
        .erase_err (erase_err),
        .prog_warn (prog_warn)
    );

    // entry: {end_of_frame, rx, expected tx}
    localparam int NV = 22;
    localparam logic [16:0] VEC [NV] = '{
        {1'b1, 8'h06, 8'h00},                                  // R6 set latch
        {1'b0, 8'h02, 8'h00}, {1'b0, 8'h00, 8'h00},            // R4 program @5
        {1'b0, 8'h00, 8'h00}, {1'b0, 8'h05, 8'h00},
        {1'b0, 8'hA5, 8'h00}, {1'b1, 8'h3C, 8'h00},
        {1'b0, 8'h03, 8'h00}, {1'b0, 8'h00, 8'h00},            // R3 read @5
        {1'b0, 8'h00, 8'h00}, {1'b0, 8'h05, 8'h00},
        {1'b0, 8'h00, 8'hA5}, {1'b0, 8'h00, 8'h3C},
        {1'b1, 8'h00, 8'hFF},
        {1'b0, 8'h9F, 8'h00}, {1'b0, 8'h00, 8'h20},            // R2 ID
        {1'b0, 8'h00, 8'hBA}, {1'b0, 8'h00, 8'h19},
        {1'b0, 8'h00, 8'h00}, {1'b0, 8'h00, 8'h00},
        {1'b0, 8'h00, 8'h00}, {1'b1, 8'h00, 8'h00}
    };

    task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] b, input logic [7:0] exp, input bit chk,
                        input string tag);
        @(negedge clk);
        cs_n = 1'b0; xfer_en = 1'b1; rx_byte = b;
        #1;
        if (chk) cmp(tag, tx_byte, exp);
        @(posedge clk);
        #1 xfer_en = 1'b0;
    endtask

    task automatic deselect();
        @(negedge clk);
        cs_n = 1'b1; xfer_en = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic flags(input string tag, input logic w, input logic e, input logic p);
        #1;
        cmp({tag, " wel"}, {7'd0, wel}, {7'd0, w});
        cmp({tag, " erase_err"}, {7'd0, erase_err}, {7'd0, e});
        cmp({tag, " prog_warn"}, {7'd0, prog_warn}, {7'd0, p});
    endtask

    task automatic op(input logic [7:0] b);
        xfer(b, 8'h00, 1'b0, "");
    endtask

    task automatic read_at(input logic [23:0] a, input logic [7:0] e0, input string tag);
        op(8'h03); op(a[23:16]); op(a[15:8]); op(a[7:0]);
        xfer(8'h00, e0, 1'b1, tag);
    endtask

    task automatic prog_at(input logic [23:0] a);
        op(8'h02); op(a[23:16]); op(a[15:8]); op(a[7:0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk);
        flags("R1 reset", 1'b0, 1'b0, 1'b0);
        read_at(24'h000000, 8'hFF, "R1 erased after reset");
        deselect();

        for (int i = 0; i < NV; i++) begin
            xfer(VEC[i][15:8], VEC[i][7:0], 1'b1, "R2/R3/R4/R11 table");
            if (VEC[i][16]) deselect();
        end
        flags("R4 latch cleared by program", 1'b0, 1'b0, 1'b0);

        op(8'h06); flags("R6 set", 1'b1, 1'b0, 1'b0); deselect();
        op(8'h04); flags("R6 clear", 1'b0, 1'b0, 1'b0); deselect();

        prog_at(24'h000005); op(8'hFF);
        flags("R5 warn on 0->1", 1'b0, 1'b0, 1'b1);
        deselect();
        prog_at(24'h000006); op(8'h0C);
        flags("R5 no warn", 1'b0, 1'b0, 1'b0);
        deselect();
        read_at(24'h000005, 8'hA5, "R4 AND keeps old"); xfer(8'h00, 8'h0C, 1'b1, "R4 AND result"); deselect();

        prog_at(24'h00003F); op(8'h11); op(8'h22); deselect();
        read_at(24'h01013F, 8'h11, "R3 upper bits ignored");
        xfer(8'h00, 8'h22, 1'b1, "R4 program wrap");
        xfer(8'h00, 8'hFF, 1'b1, "R3 read after wrap");
        deselect();

        op(8'hAB);
        xfer(8'h9F, 8'h00, 1'b1, "R8 zero stream");
        xfer(8'h03, 8'h00, 1'b1, "R8 zero stream");
        xfer(8'hFF, 8'h00, 1'b1, "R8 zero stream");
        deselect();
        op(8'h9F); xfer(8'h00, 8'h20, 1'b1, "R9 opcode after stream"); deselect();
        op(8'h03); op(8'h00); deselect();
        op(8'h9F); xfer(8'h00, 8'h20, 1'b1, "R9 opcode after aborted address"); deselect();

        op(8'h60); flags("R7 refused", 1'b0, 1'b1, 1'b0); deselect();
        read_at(24'h000005, 8'hA5, "R7 refused keeps data"); deselect();
        op(8'h06); deselect();
        op(8'hC7); flags("R7 erase", 1'b0, 1'b0, 1'b0); deselect();
        read_at(24'h000005, 8'hA5 | 8'h5A, "R7 erased"); deselect();
        read_at(24'h00003F, 8'hFF, "R7 erased far"); deselect();

        op(8'h06); op(8'h66); op(8'h99); flags("R10 armed reset", 1'b0, 1'b0, 1'b0); deselect();
        op(8'h06); op(8'h66); op(8'h06); op(8'h99); flags("R10 disarmed", 1'b1, 1'b0, 1'b0); deselect();
        op(8'h99); flags("R10 no arm", 1'b1, 1'b0, 1'b0); deselect();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule